// File: doc/BRIEF.md
# Read Latency and Data Mask Pipeline

This block sits between the column-access logic of a synchronous DRAM core and its data pins. Each read beat brings one word from the array. The block delays that word by the programmed CAS latency before it appears on the output data lines. Each output byte has its own drive enable. The mask inputs act on reads and writes on different schedules:
- On a write beat, a mask bit blocks its byte's array write in the same clock.
- On a read, a sampled mask bit turns off its output byte two clocks later, whatever the CAS latency.

A burst-stop or precharge strobe drops the read beat sampled with it. Words already in flight still drain, so CAS latency 3 gives two further words, latency 2 gives one and latency 1 gives none. A small counter tracks write recovery. It reports when enough clocks have passed since the last write word for a precharge to be issued.

Top module: `rdq_mask_align`

## Requirements
- R1: A read beat accepted at clock edge k appears on `rd_dq` with the enables in `rd_oe` set during the cycle after edge k+L-1. L is the latency selected by `cl_sel`: code 1, 2 or 3 selects that many clocks, and code 0 behaves as 1.
- R2: During a write beat, `wr_be[b]` is high exactly when `dqm[b]` is low in that same cycle, and `wr_word` carries `wr_bus` unchanged. With no write beat, `wr_be` is 0.
- R3: A `dqm[b]` value of 1 sampled at edge m clears `rd_oe[b]` during the cycle after edge m+1, independent of the latency setting.
- R4: `dqm[0]` governs bits 7:0 and `dqm[1]` governs bits 15:8, for both the read enables and the write enables.
- R5: A read beat sampled together with `burst_stop` or `pre_intr` is discarded. Beats accepted earlier still come out, which gives L-1 further words after the interrupting edge.
- R6: When a byte's enable in `rd_oe` is low, that byte of `rd_dq` is zero. Both enables are low in any cycle that carries no valid read word.
- R7: Read beats on consecutive edges produce words on consecutive cycles. A new read that follows an earlier one without a gap takes over the output with no empty cycle.
- R8: `wr_rec_ok` goes low after the edge that samples a write beat. It returns high one cycle later, so a precharge is allowed two edges after the last write word.
- R9: During and right after reset, `rd_oe` is 0, `rd_dq` is 0 and `wr_rec_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cl_sel | input | 2 | Latency code: 1, 2 or 3 clocks, with 0 treated as 1 |
| rd_beat | input | 1 | A read word is taken from the array in this cycle |
| rd_array | input | 16 | Array data for the read beat |
| wr_beat | input | 1 | A write word is on the bus in this cycle |
| wr_bus | input | 16 | Write data from the bus |
| dqm | input | 2 | Per-byte mask, bit 0 for the lower byte and bit 1 for the upper byte |
| burst_stop | input | 1 | Burst stop that cuts the read short |
| pre_intr | input | 1 | Precharge that interrupts the read |
| rd_dq | output | 16 | Output data, zero in bytes that are not driven |
| rd_oe | output | 2 | Per-byte output drive enable |
| wr_word | output | 16 | Write data toward the array |
| wr_be | output | 2 | Per-byte array write enable |
| wr_rec_ok | output | 1 | Write recovery satisfied, precharge allowed |

## Verification
A wrong latency select, or a shift stage that skips or repeats a word, puts the read word on the output in the wrong cycle. This shows at the ports as soon as the first word of a burst is due, at most three cycles after the beat. A mask stage that is off by one clears the wrong word's byte, which is visible in the cycle after the mask edge plus one. A wrong lane mapping shows on the first masked read or write. An interrupt that fails to drop its beat produces one extra word exactly L cycles later. A recovery counter that loads the wrong value flips `wr_rec_ok` one cycle early or late after every write.

// File: rtl/rdq_pkg.sv
package rdq_pkg;

  // Map a latency code to the clocks actually used; zero acts as one.
  function automatic int unsigned eff_latency(input int unsigned code,
                                              input int unsigned max_cl);
    if (code == 0) return 1;
    else if (code > max_cl) return max_cl;
    else return code;
  endfunction

  // Value loaded into the recovery counter on a write word.
  function automatic int unsigned recov_load(input int unsigned recov);
    if (recov > 0) return recov - 1;
    else return 0;
  endfunction

endpackage

// File: rtl/rdq_lat_pipe.sv
module rdq_lat_pipe #(
  parameter int DATA_W = 16,
  parameter int MAX_CL = 3,
  localparam int SEL_W = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [SEL_W-1:0]  lat_sel,
  output logic              word_vld,
  output logic [DATA_W-1:0] word_dat
);

  logic [MAX_CL-1:0] vld_q;
  logic [DATA_W-1:0] dat_q [MAX_CL];

  generate
    for (genvar s = 0; s < MAX_CL; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            vld_q[0] <= 1'b0;
            dat_q[0] <= '0;
          end else begin
            vld_q[0] <= beat_in;
            dat_q[0] <= data_in;
          end
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            vld_q[s] <= 1'b0;
            dat_q[s] <= '0;
          end else begin
            vld_q[s] <= vld_q[s-1];
            dat_q[s] <= dat_q[s-1];
          end
        end
      end
    end
  endgenerate

  // Tap the stage that matches the selected latency.
  always_comb begin
    word_vld = 1'b0;
    word_dat = '0;
    for (int s = 0; s < MAX_CL; s++) begin
      if (SEL_W'(s + 1) == lat_sel) begin
        word_vld = vld_q[s];
        word_dat = dat_q[s];
      end
    end
  end

endmodule

// File: rtl/rdq_mask_pipe.sv
module rdq_mask_pipe #(
  parameter int BYTES  = 2,
  parameter int RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BYTES-1:0] dqm,
  input  logic             wr_beat,
  output logic [BYTES-1:0] rd_mask_d,
  output logic [BYTES-1:0] wr_be
);

  logic [BYTES-1:0] m_q [RD_LAT];

  generate
    for (genvar l = 0; l < RD_LAT; l++) begin : g_dly
      if (l == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) m_q[0] <= '0;
          else        m_q[0] <= dqm;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) m_q[l] <= '0;
          else        m_q[l] <= m_q[l-1];
        end
      end
    end
  endgenerate

  assign rd_mask_d = m_q[RD_LAT-1];
  // A write mask acts on the clock that samples it.
  assign wr_be = {BYTES{wr_beat}} & ~dqm;

endmodule

// File: rtl/rdq_wr_recov.sv
module rdq_wr_recov #(
  parameter int WR_RECOV = 2,
  localparam int CNT_W = $clog2(WR_RECOV + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_beat,
  output logic rec_ok
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(rdq_pkg::recov_load(WR_RECOV));

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (wr_beat)       cnt_q <= LOAD;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign rec_ok = (cnt_q == '0);

endmodule

// File: rtl/rdq_mask_align.sv
module rdq_mask_align #(
  parameter int DATA_W      = 16,
  parameter int MAX_CL      = 3,
  parameter int RD_MASK_LAT = 2,
  parameter int WR_RECOV    = 2,
  localparam int BYTES = DATA_W / 8,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CL_W-1:0]   cl_sel,
  input  logic              rd_beat,
  input  logic [DATA_W-1:0] rd_array,
  input  logic              wr_beat,
  input  logic [DATA_W-1:0] wr_bus,
  input  logic [BYTES-1:0]  dqm,
  input  logic              burst_stop,
  input  logic              pre_intr,
  output logic [DATA_W-1:0] rd_dq,
  output logic [BYTES-1:0]  rd_oe,
  output logic [DATA_W-1:0] wr_word,
  output logic [BYTES-1:0]  wr_be,
  output logic              wr_rec_ok
);

  logic              intr_any;
  logic              beat_acc;
  logic [CL_W-1:0]   lat_sel;
  logic              word_valid;
  logic [DATA_W-1:0] word_data;
  logic [BYTES-1:0]  rd_mask_d;

  assign intr_any = burst_stop | pre_intr;
  assign beat_acc = rd_beat & ~intr_any;
  assign lat_sel  = CL_W'(rdq_pkg::eff_latency(int'(cl_sel), MAX_CL));

  rdq_lat_pipe #(.DATA_W(DATA_W), .MAX_CL(MAX_CL)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_in  (beat_acc),
    .data_in  (rd_array),
    .lat_sel  (lat_sel),
    .word_vld (word_valid),
    .word_dat (word_data)
  );

  rdq_mask_pipe #(.BYTES(BYTES), .RD_LAT(RD_MASK_LAT)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .dqm       (dqm),
    .wr_beat   (wr_beat),
    .rd_mask_d (rd_mask_d),
    .wr_be     (wr_be)
  );

  rdq_wr_recov #(.WR_RECOV(WR_RECOV)) u_recov (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_beat (wr_beat),
    .rec_ok  (wr_rec_ok)
  );

  assign rd_oe   = {BYTES{word_valid}} & ~rd_mask_d;
  assign wr_word = wr_bus;

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign rd_dq[b*8 +: 8] = rd_oe[b] ? word_data[b*8 +: 8] : 8'h00;
    end
  endgenerate

endmodule

// File: rtl/rdq_mask_align_chk.sv
module rdq_mask_align_chk #(
  parameter int DATA_W   = 16,
  parameter int MAX_CL   = 3,
  parameter int WR_RECOV = 2,
  localparam int BYTES = DATA_W / 8,
  localparam int CL_W  = $clog2(MAX_CL + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CL_W-1:0]   cl_sel,
  input logic              rd_beat,
  input logic              wr_beat,
  input logic [BYTES-1:0]  dqm,
  input logic              burst_stop,
  input logic              pre_intr,
  input logic [DATA_W-1:0] rd_dq,
  input logic [BYTES-1:0]  rd_oe,
  input logic [BYTES-1:0]  wr_be,
  input logic              wr_rec_ok,
  input logic              word_valid
);

  logic [1:0]  age_q;
  int unsigned eff_l;

  always_ff @(posedge clk) begin
    if (!rst_n)              age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  always_comb eff_l = rdq_pkg::eff_latency(int'(cl_sel), MAX_CL);

  // R1: first word of a latency-1 and latency-2 read lands on time
  p_cl1_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_beat && !burst_stop && !pre_intr && eff_l == 1) |=> word_valid);
  p_cl2_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_beat && !burst_stop && !pre_intr && eff_l == 2) |=> ##1 word_valid);

  // R5: the beat sampled with an interrupt never reaches the output
  p_cut_cl1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((burst_stop || pre_intr) && eff_l == 1) |=> (rd_oe == '0));
  p_cut_cl2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((burst_stop || pre_intr) && eff_l == 2) |=> ##1 (rd_oe == '0));
  p_cut_cl3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((burst_stop || pre_intr) && eff_l == 3) |=> ##2 (rd_oe == '0));

  // R6: enables only with a live word
  p_oe_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe != '0) |-> word_valid);

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      // R3: mask seen two edges back blanks its byte
      p_rdmask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(dqm[b], 2)) |-> !rd_oe[b]);
      // R2: write mask blocks in the same clock
      p_wmask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dqm[b] |-> !wr_be[b]);
      // R4: unmasked write lane is enabled
      p_wlane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_beat && !dqm[b]) |-> wr_be[b]);
      // R6: undriven lane reads zero
      p_idle_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_oe[b] |-> (rd_dq[b*8 +: 8] == 8'h00));
    end
    if (WR_RECOV >= 2) begin : g_rec
      // R8: recovery closes after a write word
      p_recov_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_beat |=> !wr_rec_ok);
    end
  endgenerate

endmodule

bind rdq_mask_align rdq_mask_align_chk #(
  .DATA_W(DATA_W), .MAX_CL(MAX_CL), .WR_RECOV(WR_RECOV)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cl_sel     (cl_sel),
  .rd_beat    (rd_beat),
  .wr_beat    (wr_beat),
  .dqm        (dqm),
  .burst_stop (burst_stop),
  .pre_intr   (pre_intr),
  .rd_dq      (rd_dq),
  .rd_oe      (rd_oe),
  .wr_be      (wr_be),
  .wr_rec_ok  (wr_rec_ok),
  .word_valid (word_valid)
);

// File: tb/rdq_mask_align_bench.sv
`timescale 1ns/1ps
module rdq_mask_align_bench;

  localparam int RECOV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cl_sel = 2'd1;
  logic        rd_beat = 1'b0;
  logic [15:0] rd_array = '0;
  logic        wr_beat = 1'b0;
  logic [15:0] wr_bus = '0;
  logic [1:0]  dqm = '0;
  logic        burst_stop = 1'b0;
  logic        pre_intr = 1'b0;
  logic [15:0] rd_dq;
  logic [1:0]  rd_oe;
  logic [15:0] wr_word;
  logic [1:0]  wr_be;
  logic        wr_rec_ok;

  int checks = 0;
  int fails = 0;
  int n = 0;
  bit done = 0;
  string cur_tag = "R1";
  string w_tag = "R2";

  // Model history, one entry per post-reset edge
  bit          hb [0:8191];
  logic [15:0] hd [0:8191];
  logic [1:0]  hm [0:8191];
  bit          hw [0:8191];

  always #2.5 clk = ~clk;

  rdq_mask_align u_rdq_mask_align (
    .clk(clk), .rst_n(rst_n), .cl_sel(cl_sel), .rd_beat(rd_beat),
    .rd_array(rd_array), .wr_beat(wr_beat), .wr_bus(wr_bus), .dqm(dqm),
    .burst_stop(burst_stop), .pre_intr(pre_intr), .rd_dq(rd_dq),
    .rd_oe(rd_oe), .wr_word(wr_word), .wr_be(wr_be), .wr_rec_ok(wr_rec_ok)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at step %0d: actual %h expected %h", tag, n, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [1:0] c);
    return (c == 2'd0) ? 1 : int'(c);
  endfunction

  task automatic step(input bit b, input logic [15:0] d, input logic [1:0] m,
                      input bit st, input bit pr, input bit w, input logic [15:0] wd);
    logic [1:0]  e_be, e_oe, mk;
    logic [15:0] e_dq, wdat;
    bit          v, e_ok;
    int          i;
    rd_beat = b; rd_array = d; dqm = m; burst_stop = st; pre_intr = pr;
    wr_beat = w; wr_bus = wd;
    #1;
    e_be = w ? ~m : 2'b00;
    chk(wr_be == e_be && wr_word == wd, w_tag, {14'd0, wr_be, wr_word}, {14'd0, e_be, wd});
    @(posedge clk);
    hb[n] = b && !(st || pr);
    hd[n] = d; hm[n] = m; hw[n] = w;
    @(negedge clk);
    i = n - lat_of(cl_sel) + 1;
    v = (i >= 0) ? hb[i] : 1'b0;
    wdat = (i >= 0) ? hd[i] : 16'h0;
    mk = (n >= 1) ? hm[n-1] : 2'b00;
    e_oe = {v && !mk[1], v && !mk[0]};
    e_dq = {e_oe[1] ? wdat[15:8] : 8'h00, e_oe[0] ? wdat[7:0] : 8'h00};
    chk(rd_oe == e_oe, cur_tag, {30'd0, rd_oe}, {30'd0, e_oe});
    chk(rd_dq == e_dq, cur_tag, {16'd0, rd_dq}, {16'd0, e_dq});
    e_ok = 1'b1;
    for (int j = n - RECOV + 2; j <= n; j++) if (j >= 0 && hw[j]) e_ok = 1'b0;
    chk(wr_rec_ok == e_ok, "R8", {31'd0, wr_rec_ok}, {31'd0, e_ok});
    n++;
  endtask

  task automatic idle(input int k);
    for (int q = 0; q < k; q++) step(0, 16'h0, 2'b00, 0, 0, 0, 16'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(rd_oe == 2'b00, "R9", {30'd0, rd_oe}, 32'd0);
    chk(rd_dq == 16'h0, "R9", {16'd0, rd_dq}, 32'd0);
    chk(wr_rec_ok == 1'b1, "R9", {31'd0, wr_rec_ok}, 32'd1);
    rst_n = 1'b1;
    idle(1);
    cur_tag = "R9";
    idle(1);

    // R1: each latency code, burst of four
    cur_tag = "R1";
    for (int c = 0; c < 4; c++) begin
      cl_sel = 2'(c);
      for (int k = 0; k < 4; k++) step(1, 16'hA100 + 16'(c*16 + k), 2'b00, 0, 0, 0, 16'h0);
      idle(5);
    end

    // R7: two reads back to back, then a lone read after one gap
    cur_tag = "R7";
    for (int c = 1; c < 4; c++) begin
      cl_sel = 2'(c);
      for (int k = 0; k < 3; k++) step(1, 16'h1110 + 16'(k), 2'b00, 0, 0, 0, 16'h0);
      for (int k = 0; k < 3; k++) step(1, 16'h2220 + 16'(k), 2'b00, 0, 0, 0, 16'h0);
      idle(1);
      step(1, 16'h3333, 2'b00, 0, 0, 0, 16'h0);
      idle(4);
    end

    // R3: read masks at latency 3 and 1
    cur_tag = "R3";
    cl_sel = 2'd3;
    step(1, 16'hC0C1, 2'b01, 0, 0, 0, 16'h0);
    step(1, 16'hC2C3, 2'b10, 0, 0, 0, 16'h0);
    step(1, 16'hC4C5, 2'b11, 0, 0, 0, 16'h0);
    step(1, 16'hC6C7, 2'b00, 0, 0, 0, 16'h0);
    step(1, 16'hC8C9, 2'b01, 0, 0, 0, 16'h0);
    idle(5);
    cl_sel = 2'd1;
    step(1, 16'hD0D1, 2'b10, 0, 0, 0, 16'h0);
    step(1, 16'hD2D3, 2'b00, 0, 0, 0, 16'h0);
    step(1, 16'hD4D5, 2'b01, 0, 0, 0, 16'h0);
    idle(4);

    // R4: lane mapping on writes and reads
    cur_tag = "R4"; w_tag = "R4";
    step(0, 16'h0, 2'b01, 0, 0, 1, 16'h5A5A);
    step(0, 16'h0, 2'b10, 0, 0, 1, 16'hA5A5);
    step(0, 16'h0, 2'b11, 0, 0, 1, 16'h0F0F);
    cl_sel = 2'd2;
    step(1, 16'hBEEF, 2'b00, 0, 0, 0, 16'h0);
    step(0, 16'h0, 2'b10, 0, 0, 0, 16'h0);
    idle(4);

    // R2 and R8: plain writes, gaps of various length
    w_tag = "R2"; cur_tag = "R8";
    step(0, 16'h0, 2'b00, 0, 0, 1, 16'h1234);
    idle(1);
    step(0, 16'h0, 2'b00, 0, 0, 1, 16'h4321);
    step(0, 16'h0, 2'b00, 0, 0, 1, 16'h5678);
    idle(3);
    step(0, 16'h0, 2'b11, 0, 0, 0, 16'hFFFF);
    idle(2);

    // R5: interrupts mid burst for every latency
    cur_tag = "R5";
    for (int c = 1; c < 4; c++) begin
      cl_sel = 2'(c);
      step(1, 16'hE001, 2'b00, 0, 0, 0, 16'h0);
      step(1, 16'hE002, 2'b00, 0, 0, 0, 16'h0);
      step(1, 16'hE003, 2'b00, 1, 0, 0, 16'h0);
      idle(4);
      step(1, 16'hF001, 2'b00, 0, 0, 0, 16'h0);
      step(1, 16'hF002, 2'b00, 0, 1, 0, 16'h0);
      step(1, 16'hF003, 2'b00, 0, 0, 0, 16'h0);
      idle(4);
    end

    // R6 and R1: mixed random traffic per latency
    for (int c = 1; c < 4; c++) begin
      cl_sel = 2'(c);
      cur_tag = (c == 2) ? "R6" : "R1";
      for (int k = 0; k < 250; k++) begin
        step(($urandom % 3) != 0, 16'($urandom),
             (($urandom % 3) == 0) ? 2'($urandom) : 2'b00,
             ($urandom % 11) == 0, ($urandom % 13) == 0,
             ($urandom % 4) == 0, 16'($urandom));
      end
      idle(4);
    end

    done = 1;
    summary();
    $finish;
  end

endmodule